// File: doc/BRIEF.md
# Reload Square-Wave Bit-Clock Timer

This block divides one of eight clock-enable strobes down to a symmetric square wave. It is meant to feed a receiver or transmitter as its 16x oversampling clock, or to be routed to a general-purpose output pin. Everything runs on one system clock. Each source is a strobe one system clock wide, and the counter moves only on strobes of the chosen source.

A host programs the block through a small write-only register port. Two byte registers hold the upper and lower halves of a 16-bit reload value n. A control register picks the source and starts or stops the timer. While the timer runs, the counter is loaded with n, then counts down by one on each selected strobe. When a strobe arrives with the counter at zero, the output flips and the counter is loaded again. Each half of the wave therefore lasts n+1 strobes, and the output frequency is the strobe rate divided by 2·(n+1). The values n = 0 and n = 1 are legal. For a 16x bit clock, choose n = f/(32·baud) − 1, rounded to the nearest integer.

Top module: `sqw_reload_timer`

## Requirements
- R1: After reset the output is low, the timer is stopped, the reload value is 0 and source 0 is selected.
- R2: While the timer is stopped the output stays low, whatever strobes arrive.
- R3: A control write that sets the run bit while the timer is stopped loads the counter from the current reload value and holds the output low. The first rise of the output comes on the (n+1)-th selected strobe.
- R4: While the timer runs, every half-period, high or low, lasts exactly n+1 selected strobes.
- R5: Only strobes of the source chosen by control bits [2:0] move the counter. A control write with the run bit set while the timer is already running changes the source without reloading the counter.
- R6: With n = 0 the output flips on every selected strobe.
- R7: With n = 1 the output flips on every second selected strobe.
- R8: Register addresses are fixed: 0 holds reload bits [7:0], 1 holds reload bits [15:8], and 2 is control, with bit 3 as run and bits [2:0] as source. All 16 reload bits take part.
- R9: A reload value written while the timer runs does not cut short the half-period in progress. It takes effect at the next reload.
- R10: A control write that clears the run bit drives the output low on the clock edge of the write. A later start counts a fresh n+1 strobes rather than resuming the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 8 | Clock-enable strobes, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| wave_out | output | 1 | Square-wave output |

## Verification
Every result lands on the clock edge that samples its cause. A selected strobe moves the counter and the output at that same edge. A control write starts or stops the timer at its own edge, and a stop clears the output at that edge too. The bench drives each strobe or write for a single cycle starting at a falling edge, then reads the output at the next falling edge, half a cycle after the edge that updated it. The expected level after the k-th strobe since a start is computed as floor(k/(n+1)) mod 2. The reload-change case is worked out by hand.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int SRC_COUNT = 8;
  localparam int SEL_W     = $clog2(SRC_COUNT);
  localparam int BYTE_W    = 8;

  // control byte layout: bit SEL_W is run, bits SEL_W-1:0 pick the source
  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/srt_regs.sv
module srt_regs
  import srt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [CNT_W-1:0]    reload,
  output ctrl_t               ctrl_q,
  output logic                start_p,
  output logic                stop_p
);
  localparam int NBYTES    = CNT_W / BYTE_W;
  localparam int CTRL_ADDR = NBYTES;

  logic  ctrl_wr;
  ctrl_t ctrl_new;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reload[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && addr == ADDR_W'(g))
        reload[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  assign ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
  assign start_p  = ctrl_wr &&  ctrl_new.run && !ctrl_q.run;
  assign stop_p   = ctrl_wr && !ctrl_new.run &&  ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_new;
  end
endmodule

// File: rtl/srt_tick_sel.sv
module srt_tick_sel
  import srt_pkg::*;
(
  input  logic [SRC_COUNT-1:0] ticks,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 run,
  output logic                 tick_o
);
  logic [SRC_COUNT-1:0] gated;

  for (genvar s = 0; s < SRC_COUNT; s++) begin : g_src
    assign gated[s] = ticks[s] && (sel == SEL_W'(s));
  end

  assign tick_o = run && (|gated);
endmodule

// File: rtl/srt_halfwave.sv
module srt_halfwave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wave_q,
  output logic             expire
);
  function automatic logic at_end(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r);
    return at_end(c) ? r : c - CNT_W'(1);
  endfunction

  assign expire = tick && at_end(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (start_p) begin
      cnt_q  <= reload;
      wave_q <= 1'b0;
    end else if (stop_p || !run) begin
      wave_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= next_count(cnt_q, reload);
      if (expire) wave_q <= !wave_q;
    end
  end
endmodule

// File: rtl/sqw_reload_timer.sv
module sqw_reload_timer
  import srt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] src_tick,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [BYTE_W-1:0]    reg_wdata,
  output logic                 wave_out
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl;
  logic             start_p, stop_p, sel_tick, expire, run;

  srt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .reload(reload), .ctrl_q(ctrl), .start_p(start_p), .stop_p(stop_p)
  );

  assign run = ctrl.run;

  srt_tick_sel sel_i (
    .ticks(src_tick), .sel(ctrl.sel), .run(run), .tick_o(sel_tick)
  );

  srt_halfwave #(.CNT_W(CNT_W)) wave_i (
    .clk(clk), .rst_n(rst_n), .tick(sel_tick), .start_p(start_p), .stop_p(stop_p),
    .run(run), .reload(reload), .cnt_q(cnt), .wave_q(wave_out), .expire(expire)
  );
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             start_p,
  input logic             stop_p,
  input logic             sel_tick,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             wave_out
);
  p_stopped_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !wave_out);

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (cnt == $past(reload)) && !wave_out);

  p_expire_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !stop_p) |=> (wave_out != $past(wave_out)) && (cnt == $past(reload)));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tick && !expire && !stop_p) |=> (cnt == $past(cnt) - CNT_W'(1)) && $stable(wave_out));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel_tick && !stop_p) |=> $stable(cnt) && $stable(wave_out));

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !wave_out && !run);
endmodule

bind sqw_reload_timer srt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .start_p(start_p), .stop_p(stop_p),
  .sel_tick(sel_tick), .expire(expire), .cnt(cnt), .reload(reload), .wave_out(wave_out)
);

// File: tb/sqw_reload_timer_tb_top.sv
`timescale 1ns/1ps
module sqw_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_tick = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       wave_out;

  int n_tests = 0;
  int n_fail  = 0;
  int k;
  bit done = 0;

  always #2.5 clk = ~clk;

  sqw_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wave_out(wave_out)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_reload(int n);  // R8: low byte at 0, high byte at 1
    wr(2'd0, n[7:0]);
    wr(2'd1, n[15:8]);
  endtask

  task automatic set_ctrl(int sel, bit run);  // R8: run bit 3, source bits 2:0
    wr(2'd2, {4'b0, run, sel[2:0]});
  endtask

  task automatic pulse(logic [7:0] mask);
    @(negedge clk);
    src_tick = mask;
    @(negedge clk);
    src_tick = '0;
  endtask

  function automatic int model(int kk, int n);
    return (kk / (n + 1)) % 2;
  endfunction

  task automatic t_reset();
    chk("R1 reset output", wave_out, 0);
    for (int i = 0; i < 5; i++) begin
      pulse(8'hFF);
      chk("R2 stopped ignores strobes", wave_out, 0);
    end
    set_ctrl(0, 1);
    chk("R1 start after reset", wave_out, 0);
    for (int i = 1; i <= 4; i++) begin
      pulse(8'h01);
      chk("R1 reset reload is zero", wave_out, i % 2);
    end
    set_ctrl(0, 0);
    chk("R10 stop clears", wave_out, 0);
  endtask

  task automatic t_div(string req, int n, int src);
    set_reload(n);
    set_ctrl(src, 1);
    chk(req, wave_out, 0);
    k = 0;
    for (int i = 0; i < 4 * (n + 1); i++) begin
      pulse(8'(1 << src));
      k++;
      chk(req, wave_out, model(k, n));
    end
    set_ctrl(src, 0);
    chk("R10 stop clears", wave_out, 0);
  endtask

  task automatic t_select();
    set_reload(2);
    set_ctrl(4, 1);
    k = 0;
    for (int i = 0; i < 4; i++) begin
      pulse(8'h10); k++;
      chk("R5 selected source counts", wave_out, model(k, 2));
    end
    for (int i = 0; i < 10; i++) begin
      pulse(8'hEF);
      chk("R5 other sources ignored", wave_out, model(k, 2));
    end
    for (int i = 0; i < 3; i++) begin
      pulse(8'h10); k++;
      chk("R5 count resumes", wave_out, model(k, 2));
    end
    set_ctrl(6, 1);  // reselect while running: no reload
    for (int i = 0; i < 3; i++) begin
      pulse(8'h10);
      chk("R5 old source ignored after reselect", wave_out, model(k, 2));
    end
    for (int i = 0; i < 8; i++) begin
      pulse(8'h40); k++;
      chk("R5 new source continues count", wave_out, model(k, 2));
    end
    set_ctrl(6, 0);
  endtask

  task automatic t_reload_change();
    int exp_lv[9] = '{0, 0, 0, 0, 1, 1, 0, 0, 1};
    set_reload(4);
    set_ctrl(1, 1);
    for (int i = 0; i < 9; i++) begin
      if (i == 2) set_reload(1);
      pulse(8'h02);
      chk("R9 reload change at next half", wave_out, exp_lv[i]);
    end
    set_ctrl(1, 0);
  endtask

  task automatic t_stop_restart();
    set_reload(2);
    set_ctrl(3, 1);
    for (int i = 1; i <= 4; i++) pulse(8'h08);
    chk("R4 high after first half", wave_out, 1);
    set_ctrl(3, 0);
    chk("R10 stop drives low", wave_out, 0);
    for (int i = 0; i < 4; i++) begin
      pulse(8'h08);
      chk("R2 stopped stays low", wave_out, 0);
    end
    set_ctrl(3, 1);
    chk("R3 start holds low", wave_out, 0);
    for (int i = 1; i <= 3; i++) begin
      pulse(8'h08);
      chk("R10 restart counts fresh", wave_out, (i == 3) ? 1 : 0);
    end
    set_ctrl(3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div("R3 R4 divide n=3", 3, 2);
    t_div("R6 n=0 flips each strobe", 0, 0);
    t_div("R7 n=1 flips every second strobe", 1, 7);
    t_div("R8 16-bit reload n=0x0102", 16'h0102, 5);
    t_select();
    t_reload_change();
    t_stop_restart();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule